// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block turns the packed control word of an on-chip PLL into a target frequency. It then searches every setting of an external frequency synthesizer for the one whose output lands closest to that target. The synthesizer has an output divider, a reference divider and a VCO feedback divider. A setting counts only when its VCO frequency lies inside an allowed window and its comparison frequency is high enough. All arithmetic is integer; every division truncates.

A single `start` pulse latches the control word and runs the search. The block tries one candidate per clock and keeps `busy` high until the last candidate is done. It then pulses `done` for one cycle. After that it holds the best divider triple, the 3-bit select code for the chosen output divider, a found flag and the target frequency until the next accepted start. The ranges and limits are parameters. The defaults span the full synthesizer range, 8 x 127 x 508 candidates.

Top module: `pll_div_search`

## Requirements
- R1: The target is computed from the control word as follows: n = word[15:8] + 2, m = word[7:2] + 2, k = word[1:0]. The target is ((14318180*n / m) >> k) >> 2, where each division truncates. When found = 1, freq_hz shows this target.
- R2: An accepted start raises busy at the next clock edge. busy stays high for exactly one cycle per candidate (8 x R-count x V-count). done is high for exactly one cycle, at the edge where busy falls.
- R3: Candidates are visited with the output divider outermost, in the order 2, 3, 4, 5, 6, 7, 8, 10. The reference divider R runs from R_LO to R_HI in the middle loop, and the VCO divider V runs from V_LO to V_HI innermost.
- R4: A candidate is eligible only if 55 MHz < 2*14318180*(V+8)/(R+2) < 400 MHz, with both bounds strict.
- R5: A candidate is eligible only if the truncated quotient 14318180/(R+2) is greater than 200000. With the default reference, R = 69 passes and R = 70 fails.
- R6: The candidate frequency is the truncated 2*14318180*(V+8)/((R+2)*OD). The error is its absolute difference from the target. The best error starts at 500,000,000. An eligible candidate replaces the best only when its error is strictly smaller, so the earliest of equal candidates is kept.
- R7: s_code encodes the chosen output divider as 2->1, 3->6, 4->3, 5->4, 6->7, 7->5, 8->2, 10->0.
- R8: If no candidate is eligible, found is 0 and freq_hz is 0 after done.
- R9: A start while busy is ignored. The sweep in progress keeps its target and its length, and its result is unchanged.
- R10: After reset, busy, done and found are 0 and freq_hz is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| ctrl_word | input | 16 | Packed PLL control word, sampled at an accepted start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a search |
| found | output | 1 | At least one eligible candidate was seen |
| best_od | output | 4 | Chosen output divider value |
| best_r | output | R_W (7) | Chosen reference divider |
| best_v | output | V_W (9) | Chosen VCO divider |
| s_code | output | 3 | Select code for best_od |
| freq_hz | output | 32 | Target frequency when found, else 0 |

## Verification
The main instance is driven with four control words. They cover the extreme field values, a large pre-divide exponent and a mid-range word, so that errors in the field extraction, in the shifts and in the selection are told apart. A reference model in the bench sweeps the same ranges and predicts the winning triple, including the strict-improvement tie rule. Two small instances isolate the limits. In one, the only R/V pair sits just above the VCO ceiling, so nothing qualifies. In the other, R straddles the comparison-frequency boundary at 69/70, so a wrong bound shows up as the wrong R. A start injected mid-sweep with a different word shows whether the block re-latched the word or restarted the sweep.

// File: rtl/pll_search_pkg.sv
// Shared constants and small lookup functions for the PLL divider search.
// Assumes a 16-bit packed PLL control word and eight output-divider steps.
package pll_search_pkg;
    localparam int CW_W     = 16;
    localparam int NUM_OD   = 8;
    localparam int OD_IDX_W = $clog2(NUM_OD);
    localparam int OD_W     = 4;

    // Output divider value for a sweep step; the step order is the search order.
    function automatic logic [OD_W-1:0] od_value(input logic [OD_IDX_W-1:0] idx);
        case (idx)
            3'd0:    od_value = 4'd2;
            3'd1:    od_value = 4'd3;
            3'd2:    od_value = 4'd4;
            3'd3:    od_value = 4'd5;
            3'd4:    od_value = 4'd6;
            3'd5:    od_value = 4'd7;
            3'd6:    od_value = 4'd8;
            default: od_value = 4'd10;
        endcase
    endfunction

    // Synthesizer select code for a sweep step.
    function automatic logic [2:0] s_code_of(input logic [OD_IDX_W-1:0] idx);
        case (idx)
            3'd0:    s_code_of = 3'd1;
            3'd1:    s_code_of = 3'd6;
            3'd2:    s_code_of = 3'd3;
            3'd3:    s_code_of = 3'd4;
            3'd4:    s_code_of = 3'd7;
            3'd5:    s_code_of = 3'd5;
            3'd6:    s_code_of = 3'd2;
            default: s_code_of = 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/pll_target_calc.sv
// Target frequency from the packed PLL control word.
// Purely combinational. Assumes the result fits FREQ_W bits; with the
// default reference the largest value is below 2^29.
module pll_target_calc
    import pll_search_pkg::*;
#(
    parameter longint unsigned REF_HZ = 64'd14318180,
    parameter int              FREQ_W = 32,
    parameter int              XW     = 48
) (
    input  logic [CW_W-1:0]   ctrl_word,
    output logic [FREQ_W-1:0] tgt
);
    localparam logic [XW-1:0] REF_X = XW'(REF_HZ);

    logic [XW-1:0] n_x, m_x, quot;
    logic [1:0]    k;

    // Field extraction, multiply, divide and power-of-two scaling.
    always_comb begin
        n_x  = XW'(ctrl_word[15:8]) + XW'(2);
        m_x  = XW'(ctrl_word[7:2]) + XW'(2);
        k    = ctrl_word[1:0];
        quot = (REF_X * n_x) / m_x;
        tgt  = FREQ_W'((quot >> k) >> 2);
    end
endmodule

// File: rtl/pll_sweep_ctr.sv
// Nested sweep counter: output-divider step outermost, R middle, V innermost.
// Assumes R_LO <= R_HI and V_LO <= V_HI; load restarts at the first candidate.
module pll_sweep_ctr
    import pll_search_pkg::*;
#(
    parameter int R_LO = 1,
    parameter int R_HI = 127,
    parameter int V_LO = 4,
    parameter int V_HI = 511,
    localparam int R_W = $clog2(R_HI + 1),
    localparam int V_W = $clog2(V_HI + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    output logic [OD_IDX_W-1:0] od_idx,
    output logic [R_W-1:0]      r,
    output logic [V_W-1:0]      v,
    output logic                last
);
    localparam logic [R_W-1:0]      R_FIRST = R_W'(R_LO);
    localparam logic [R_W-1:0]      R_LAST  = R_W'(R_HI);
    localparam logic [V_W-1:0]      V_FIRST = V_W'(V_LO);
    localparam logic [V_W-1:0]      V_LAST  = V_W'(V_HI);
    localparam logic [OD_IDX_W-1:0] OD_LAST = OD_IDX_W'(NUM_OD - 1);

    // Advance V, carrying into R and then into the output-divider step.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            od_idx <= '0;
            r      <= R_FIRST;
            v      <= V_FIRST;
        end else if (step) begin
            if (v == V_LAST) begin
                v <= V_FIRST;
                if (r == R_LAST) begin
                    r      <= R_FIRST;
                    od_idx <= od_idx + 1'b1;
                end else begin
                    r <= r + 1'b1;
                end
            end else begin
                v <= v + 1'b1;
            end
        end
    end

    // Final candidate of the sweep.
    assign last = (od_idx == OD_LAST) && (r == R_LAST) && (v == V_LAST);
endmodule

// File: rtl/pll_cand_eval.sv
// Evaluates one candidate: eligibility under the VCO window and the
// comparison-frequency floor, plus its absolute error against the target.
// Purely combinational. Assumes XW holds 2*REF*(V_HI+8) times the VCO limit scale.
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter longint unsigned REF_HZ     = 64'd14318180,
    parameter longint unsigned VCO_MIN_HZ = 64'd55000000,
    parameter longint unsigned VCO_MAX_HZ = 64'd400000000,
    parameter longint unsigned PFD_MIN_HZ = 64'd200000,
    parameter int              R_W        = 7,
    parameter int              V_W        = 9,
    parameter int              FREQ_W     = 32,
    parameter int              XW         = 48
) (
    input  logic [FREQ_W-1:0]   tgt,
    input  logic [OD_IDX_W-1:0] od_idx,
    input  logic [R_W-1:0]      r,
    input  logic [V_W-1:0]      v,
    output logic                ok,
    output logic [XW-1:0]       err
);
    localparam logic [XW-1:0] REF_X     = XW'(REF_HZ);
    localparam logic [XW-1:0] VMIN_X    = XW'(VCO_MIN_HZ);
    localparam logic [XW-1:0] VMAX_X    = XW'(VCO_MAX_HZ);
    localparam logic [XW-1:0] PFD_NEXT  = XW'(PFD_MIN_HZ + 1);

    logic [XW-1:0] num, rden, den, cand, tgt_x;
    logic          vco_ok, pfd_ok;

    // Cross-multiplied limit checks, then the truncated candidate and its error.
    always_comb begin
        num    = XW'(2) * REF_X * (XW'(v) + XW'(8));
        rden   = XW'(r) + XW'(2);
        den    = rden * XW'(od_value(od_idx));
        vco_ok = (num > VMIN_X * rden) && (num < VMAX_X * rden);
        pfd_ok = REF_X >= PFD_NEXT * rden;
        cand   = num / den;
        tgt_x  = XW'(tgt);
        err    = (cand >= tgt_x) ? (cand - tgt_x) : (tgt_x - cand);
        ok     = vco_ok && pfd_ok;
    end
endmodule

// File: rtl/pll_div_search.sv
// Top of the PLL divider search. A start while idle latches the target and
// sweeps every candidate, one per clock, keeping the strictly best one.
// Assumes a single clock domain and a synchronous active-low reset.
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter longint unsigned REF_HZ      = 64'd14318180,
    parameter longint unsigned VCO_MIN_HZ  = 64'd55000000,
    parameter longint unsigned VCO_MAX_HZ  = 64'd400000000,
    parameter longint unsigned PFD_MIN_HZ  = 64'd200000,
    parameter longint unsigned ERR_INIT_HZ = 64'd500000000,
    parameter int              R_LO        = 1,
    parameter int              R_HI        = 127,
    parameter int              V_LO        = 4,
    parameter int              V_HI        = 511,
    parameter int              FREQ_W      = 32,
    parameter int              XW          = 48,
    localparam int             R_W         = $clog2(R_HI + 1),
    localparam int             V_W         = $clog2(V_HI + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CW_W-1:0]   ctrl_word,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [OD_W-1:0]   best_od,
    output logic [R_W-1:0]    best_r,
    output logic [V_W-1:0]    best_v,
    output logic [2:0]        s_code,
    output logic [FREQ_W-1:0] freq_hz
);
    localparam logic [XW-1:0] ERR_INIT = XW'(ERR_INIT_HZ);

    logic                busy_q, done_q, found_q, accept;
    logic [FREQ_W-1:0]   tgt_next, tgt_q;
    logic [OD_IDX_W-1:0] od_idx, best_idx;
    logic [R_W-1:0]      r_cur;
    logic [V_W-1:0]      v_cur;
    logic                last, cand_ok;
    logic [XW-1:0]       cand_err, best_err;

    assign accept = start && !busy_q;

    pll_target_calc #(.REF_HZ(REF_HZ), .FREQ_W(FREQ_W), .XW(XW)) u_tgt (
        .ctrl_word (ctrl_word),
        .tgt       (tgt_next)
    );

    pll_sweep_ctr #(.R_LO(R_LO), .R_HI(R_HI), .V_LO(V_LO), .V_HI(V_HI)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (busy_q),
        .od_idx (od_idx),
        .r      (r_cur),
        .v      (v_cur),
        .last   (last)
    );

    pll_cand_eval #(
        .REF_HZ(REF_HZ), .VCO_MIN_HZ(VCO_MIN_HZ), .VCO_MAX_HZ(VCO_MAX_HZ),
        .PFD_MIN_HZ(PFD_MIN_HZ), .R_W(R_W), .V_W(V_W), .FREQ_W(FREQ_W), .XW(XW)
    ) u_eval (
        .tgt    (tgt_q),
        .od_idx (od_idx),
        .r      (r_cur),
        .v      (v_cur),
        .ok     (cand_ok),
        .err    (cand_err)
    );

    // Latch the target only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      tgt_q <= '0;
        else if (accept) tgt_q <= tgt_next;
    end

    // Sweep control: busy for the whole sweep, done for one cycle after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q && last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    // Best-match tracking with strict improvement.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            best_err <= ERR_INIT;
            found_q  <= 1'b0;
            best_idx <= '0;
            best_r   <= '0;
            best_v   <= '0;
        end else if (busy_q && cand_ok && (cand_err < best_err)) begin
            best_err <= cand_err;
            found_q  <= 1'b1;
            best_idx <= od_idx;
            best_r   <= r_cur;
            best_v   <= v_cur;
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign found   = found_q;
    assign best_od = od_value(best_idx);
    assign s_code  = s_code_of(best_idx);
    assign freq_hz = found_q ? tgt_q : '0;
endmodule

// File: rtl/pll_div_search_chk.sv
// Property checker for pll_div_search, attached by bind. It re-derives the
// limits on the reported best triple and checks the sweep handshake.
module pll_div_search_chk #(
    parameter longint unsigned REF_HZ     = 64'd14318180,
    parameter longint unsigned VCO_MIN_HZ = 64'd55000000,
    parameter longint unsigned VCO_MAX_HZ = 64'd400000000,
    parameter longint unsigned PFD_MIN_HZ = 64'd200000,
    parameter int              R_W        = 7,
    parameter int              V_W        = 9,
    parameter int              FREQ_W     = 32,
    parameter int              XW         = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic [3:0]        best_od,
    input logic [R_W-1:0]    best_r,
    input logic [V_W-1:0]    best_v,
    input logic [2:0]        s_code,
    input logic [FREQ_W-1:0] freq_hz,
    input logic [FREQ_W-1:0] tgt_q,
    input logic [XW-1:0]     best_err
);
    logic [XW-1:0] b_num, b_rden;
    logic [2:0]    exp_code;

    // Limits of the reported triple and the code expected for its divider.
    always_comb begin
        b_num  = XW'(2) * XW'(REF_HZ) * (XW'(best_v) + XW'(8));
        b_rden = XW'(best_r) + XW'(2);
        case (best_od)
            4'd2:    exp_code = 3'd1;
            4'd3:    exp_code = 3'd6;
            4'd4:    exp_code = 3'd3;
            4'd5:    exp_code = 3'd4;
            4'd6:    exp_code = 3'd7;
            4'd7:    exp_code = 3'd5;
            4'd8:    exp_code = 3'd2;
            default: exp_code = 3'd0;
        endcase
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r4_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (b_num > XW'(VCO_MIN_HZ) * b_rden) && (b_num < XW'(VCO_MAX_HZ) * b_rden));
    a_r5_pfd_floor: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (XW'(REF_HZ) / b_rden) > XW'(PFD_MIN_HZ));
    a_r6_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_err <= $past(best_err)));
    a_r7_code_map: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (s_code == exp_code));
    a_r8_zero_freq: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (freq_hz == '0));
    a_r9_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tgt_q));
endmodule

bind pll_div_search pll_div_search_chk #(
    .REF_HZ(REF_HZ), .VCO_MIN_HZ(VCO_MIN_HZ), .VCO_MAX_HZ(VCO_MAX_HZ),
    .PFD_MIN_HZ(PFD_MIN_HZ), .R_W(R_W), .V_W(V_W), .FREQ_W(FREQ_W), .XW(XW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .best_od  (best_od),
    .best_r   (best_r),
    .best_v   (best_v),
    .s_code   (s_code),
    .freq_hz  (freq_hz),
    .tgt_q    (tgt_q),
    .best_err (best_err)
);

// File: tb/pll_div_search_tb_top.sv
// Directed bench: one task per scenario, each checking its own results
// against a reference sweep computed here from the requirements.
module pll_div_search_tb_top;
    localparam longint REF = 64'd14318180;
    localparam int M_RLO = 1, M_RHI = 20, M_VLO = 4, M_VHI = 80;
    localparam int N_RLO = 1, N_RHI = 1, N_VLO = 34, N_VHI = 41;
    localparam int P_RLO = 69, P_RHI = 70, P_VLO = 140, P_VHI = 147;
    localparam int M_RW = $clog2(M_RHI + 1), M_VW = $clog2(M_VHI + 1);
    localparam int N_RW = $clog2(N_RHI + 1), N_VW = $clog2(N_VHI + 1);
    localparam int P_RW = $clog2(P_RHI + 1), P_VW = $clog2(P_VHI + 1);
    localparam int WATCHDOG = 190000;

    int od_t[8] = '{2, 3, 4, 5, 6, 7, 8, 10};
    int sc_t[8] = '{1, 6, 3, 4, 7, 5, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, start_s = 1'b0;
    logic [15:0] word = '0, word_s = '0;

    logic busy_m, done_m, found_m;
    logic [3:0] od_m; logic [M_RW-1:0] r_m; logic [M_VW-1:0] v_m;
    logic [2:0] sc_m; logic [31:0] f_m;
    logic busy_n, done_n, found_n;
    logic [3:0] od_n; logic [N_RW-1:0] r_n; logic [N_VW-1:0] v_n;
    logic [2:0] sc_n; logic [31:0] f_n;
    logic busy_p, done_p, found_p;
    logic [3:0] od_p; logic [P_RW-1:0] r_p; logic [P_VW-1:0] v_p;
    logic [2:0] sc_p; logic [31:0] f_p;

    int nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    pll_div_search #(.R_LO(M_RLO), .R_HI(M_RHI), .V_LO(M_VLO), .V_HI(M_VHI)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(word),
        .busy(busy_m), .done(done_m), .found(found_m), .best_od(od_m),
        .best_r(r_m), .best_v(v_m), .s_code(sc_m), .freq_hz(f_m));

    pll_div_search #(.R_LO(N_RLO), .R_HI(N_RHI), .V_LO(N_VLO), .V_HI(N_VHI)) dut_none_i (
        .clk(clk), .rst_n(rst_n), .start(start_s), .ctrl_word(word_s),
        .busy(busy_n), .done(done_n), .found(found_n), .best_od(od_n),
        .best_r(r_n), .best_v(v_n), .s_code(sc_n), .freq_hz(f_n));

    pll_div_search #(.R_LO(P_RLO), .R_HI(P_RHI), .V_LO(P_VLO), .V_HI(P_VHI)) dut_pfd_i (
        .clk(clk), .rst_n(rst_n), .start(start_s), .ctrl_word(word_s),
        .busy(busy_p), .done(done_p), .found(found_p), .best_od(od_p),
        .best_r(r_p), .best_v(v_p), .s_code(sc_p), .freq_hz(f_p));

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint target_of(input logic [15:0] w);
        longint n, m, q;
        n = longint'(w[15:8]) + 2;
        m = longint'(w[7:2]) + 2;
        q = (REF * n) / m;
        return (q >> w[1:0]) >> 2;
    endfunction

    // Reference sweep in search order with the strict-improvement rule.
    task automatic model(input longint tgt, input int rlo, input int rhi, input int vlo,
                         input int vhi, output int b_i, output int b_r, output int b_v,
                         output bit b_f);
        longint best;
        best = 500000000;
        b_i = 0; b_r = 0; b_v = 0; b_f = 1'b0;
        for (int i = 0; i < 8; i++)
            for (int r = rlo; r <= rhi; r++)
                for (int v = vlo; v <= vhi; v++) begin
                    longint num, rd, c, e;
                    num = 2 * REF * longint'(v + 8);
                    rd  = longint'(r + 2);
                    c   = num / (rd * od_t[i]);
                    e   = (c > tgt) ? c - tgt : tgt - c;
                    if (num > 55000000 * rd && num < 400000000 * rd &&
                        REF / rd > 200000 && e < best) begin
                        best = e; b_i = i; b_r = r; b_v = v; b_f = 1'b1;
                    end
                end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R10", "busy after reset", busy_m, 0);
        chk_eq("R10", "done after reset", done_m, 0);
        chk_eq("R10", "found after reset", found_m, 0);
        chk_eq("R10", "freq after reset", f_m, 0);
    endtask

    // Full sweep on the main instance; optionally a second start mid-sweep.
    task automatic t_search(input logic [15:0] w, input bit inject, input logic [15:0] w2);
        int cnt, b_i, b_r, b_v;
        bit b_f;
        longint tgt;
        tgt = target_of(w);
        model(tgt, M_RLO, M_RHI, M_VLO, M_VHI, b_i, b_r, b_v, b_f);
        @(negedge clk);
        word = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R2", "busy after start", busy_m, 1);
        cnt = 0;
        while (!done_m) begin
            if (busy_m) cnt++;
            if (inject && cnt == 50) begin
                word = w2; start = 1'b1;       // R9: must be ignored
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk_eq(inject ? "R9" : "R2", "busy cycles", cnt, 8 * (M_RHI - M_RLO + 1) * (M_VHI - M_VLO + 1));
        chk_eq("R1", "target freq", f_m, b_f ? tgt : 0);
        chk_eq("R6", "found", found_m, b_f);
        chk_eq("R3", "best od", od_m, od_t[b_i]);
        chk_eq("R6", "best r", r_m, b_r);
        chk_eq("R6", "best v", v_m, b_v);
        chk_eq("R7", "s code", sc_m, sc_t[b_i]);
        @(negedge clk);
        chk_eq("R2", "done width", done_m, 0);
        chk_eq("R2", "idle after done", busy_m, 0);
    endtask

    // Limit-edge instances: VCO ceiling (none eligible) and comparison floor 69/70.
    task automatic t_limits(input logic [15:0] w);
        int b_i, b_r, b_v;
        bit b_f, seen_n, seen_p;
        longint tgt;
        tgt = target_of(w);
        @(negedge clk);
        word_s = w; start_s = 1'b1;
        @(negedge clk);
        start_s = 1'b0;
        seen_n = 1'b0; seen_p = 1'b0;
        while (!(seen_n && seen_p)) begin
            if (done_n) seen_n = 1'b1;
            if (done_p) seen_p = 1'b1;
            @(negedge clk);
        end
        chk_eq("R4", "found with all VCO too high", found_n, 0);
        chk_eq("R8", "freq with none eligible", f_n, 0);
        model(tgt, P_RLO, P_RHI, P_VLO, P_VHI, b_i, b_r, b_v, b_f);
        chk_eq("R5", "found at floor edge", found_p, 1);
        chk_eq("R5", "r at floor edge", r_p, 69);
        chk_eq("R5", "v at floor edge", v_p, b_v);
        chk_eq("R3", "od at floor edge", od_p, od_t[b_i]);
        chk_eq("R1", "freq at floor edge", f_p, tgt);
    endtask

    initial begin : main
        t_reset();
        t_search({8'h40, 6'd16, 2'd1}, 1'b0, 16'h0);
        t_search({8'h00, 6'd0, 2'd0}, 1'b0, 16'h0);
        t_search({8'hFF, 6'h3F, 2'd0}, 1'b0, 16'h0);
        t_search({8'hC8, 6'd40, 2'd3}, 1'b1, {8'hFF, 6'd0, 2'd0});
        t_limits({8'h40, 6'd16, 2'd1});
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule